// File: doc/BRIEF.md
# Block-Lookahead Decimal Adder

This block adds two packed decimal operands of `NDIG` digits each, plus a single carry-in bit. It returns the decimal sum, registered, and a decimal carry-out. The digits are split into equal groups of `MDIG` neighbouring digits. Every digit first works out, straight from its two operand digits, whether it creates a decimal carry on its own (the digit pair totals 10 or more) and whether it would pass on an incoming carry (the pair totals exactly 9).

Each group combines these per-digit flags in a lookahead term. The term gives the group's carry-out twice in advance: once for an incoming carry of 0 and once for an incoming carry of 1. The carry that actually reaches the group then only picks one of the two, so the carry crosses each group through a single 2:1 select.

Inside a group, each digit takes its carry from a short select chain and fixes its raw binary total with a conditional add of six. For the shortest path, the group size is best chosen near the square root of half the digit count. The result is captured in an output register that has a synchronous active-low reset.

Top module: `hbcd_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge loads `sum` with zero and `cout` with 0.
- R2: Outputs change only at a rising edge, and they show the operands and carry-in present at that edge. Input changes between edges leave the outputs unchanged.
- R3: For operands A and B with valid digits (each 0 to 9) and carry-in c, `sum` equals (A+B+c) mod 10^NDIG and `cout` is 1 exactly when A+B+c reaches 10^NDIG.
- R4: For valid operands, every 4-bit digit of `sum` lies between 0 and 9.
- R5: Digit i of every operand and of `sum` sits in bits [4i+3:4i], and digit 0 is the least significant.
- R6: When every digit pair totals exactly 9, `cout` equals `cin`. `sum` is then all nines if `cin` is 0 and all zeros if `cin` is 1.
- R7: A carry created in digit 0 travels through any run of digit pairs that total 9, across every group boundary, and reaches `cout`. A digit pair totalling less than 9 stops it.
- R8: In each group, the carry-out chosen by the lookahead select equals the carry that leaves the group's last digit through the digit-by-digit chain.
- R9: Any `MDIG` of at least 1 that divides `NDIG` is accepted and gives identical results, including `MDIG` = 1 and `MDIG` = `NDIG`. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a | input | 4*NDIG | First packed decimal operand |
| b | input | 4*NDIG | Second packed decimal operand |
| cin | input | 1 | Decimal carry-in |
| sum | output | 4*NDIG | Registered packed decimal sum |
| cout | output | 1 | Registered decimal carry-out |

## Verification
In one cycle, the group lookahead and the in-group digit chain can both carry a single carry that must cross a group boundary. They agree only if the precomputed pair and the select line up with the rippled digit carries. This is provoked with a generating low digit followed by long runs of nine-sum digit pairs, optionally broken by a digit pair that stops the carry, and with both carry-in values on all-propagate operands. The result is judged against a decimal reference built from integer arithmetic, on four instances whose group sizes range from one digit to the full width.

// File: rtl/hbcd_pkg.sv
// hbcd_pkg: shared digit type and the per-digit correction helper.
// Assumes digit totals fit five bits (two valid digits plus a carry).
package hbcd_pkg;
    localparam int DIG_W = 4;
    localparam int RAW_W = 5;

    typedef logic [DIG_W-1:0] digit_t;

    // Fold a raw binary digit total plus its carry-in into one decimal digit,
    // adding six when the digit emits a decimal carry.
    function automatic digit_t fix_digit(input logic [RAW_W-1:0] raw,
                                         input logic c_in,
                                         input logic c_out);
        logic [RAW_W-1:0] t;
        t = raw + {{(RAW_W-1){1'b0}}, c_in};
        if (c_out) begin
            t = t + 5'd6;
        end
        return t[DIG_W-1:0];
    endfunction
endpackage

// File: rtl/hbcd_digit_flags.sv
// hbcd_digit_flags: for every digit at once, forms the raw binary total of
// the two operand digits and two flags: gen (total >= 10) and prop
// (total == 9). Assumes operand digits are valid decimal digits.
module hbcd_digit_flags #(
    parameter int NDIG = 8
) (
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    output logic [5*NDIG-1:0] raw_vec,
    output logic [NDIG-1:0]   gen_vec,
    output logic [NDIG-1:0]   prop_vec
);
    import hbcd_pkg::*;

    for (genvar gi = 0; gi < NDIG; gi++) begin : g_dig
        logic [RAW_W-1:0] raw;

        // Binary total of one digit pair and its two carry flags.
        always_comb begin
            raw = {1'b0, a[4*gi +: 4]} + {1'b0, b[4*gi +: 4]};
            raw_vec[5*gi +: 5] = raw;
            gen_vec[gi]        = (raw >= 5'd10);
            prop_vec[gi]       = (raw == 5'd9);
        end
    end
endmodule

// File: rtl/hbcd_block_lookahead.sv
// hbcd_block_lookahead: for one group of MDIG digits, computes the group
// carry-out for carry-in 0 (k0) and carry-in 1 (k1) from the digit flags,
// then picks one with the actual group carry-in.
module hbcd_block_lookahead #(
    parameter int MDIG = 2
) (
    input  logic [MDIG-1:0] gen_blk,
    input  logic [MDIG-1:0] prop_blk,
    input  logic            blk_cin,
    output logic            blk_cout
);
    logic k0;
    logic k1;

    // Sum over digits of gen_i gated by all propagates above digit i.
    always_comb begin
        logic pass;
        k0 = 1'b0;
        for (int i = 0; i < MDIG; i++) begin
            pass = 1'b1;
            for (int j = i + 1; j < MDIG; j++) begin
                pass = pass & prop_blk[j];
            end
            k0 = k0 | (gen_blk[i] & pass);
        end
        k1 = k0 | (&prop_blk);
    end

    // The one select on the inter-group carry path.
    always_comb begin
        blk_cout = blk_cin ? k1 : k0;
    end
endmodule

// File: rtl/hbcd_block_sum.sv
// hbcd_block_sum: forms the MDIG decimal sum digits of one group. The digit
// carry moves through one select per digit, and each digit is then corrected.
// Assumes the group carry-in arrives from the lookahead select chain.
module hbcd_block_sum #(
    parameter int MDIG = 2
) (
    input  logic [5*MDIG-1:0] raw_blk,
    input  logic [MDIG-1:0]   gen_blk,
    input  logic [MDIG-1:0]   prop_blk,
    input  logic              blk_cin,
    output logic [4*MDIG-1:0] sum_blk,
    output logic              chain_cout
);
    import hbcd_pkg::*;

    logic [MDIG:0] dc;

    assign dc[0]      = blk_cin;
    assign chain_cout = dc[MDIG];

    for (genvar gi = 0; gi < MDIG; gi++) begin : g_dig
        // Per-digit carry select: k1 = gen|prop, k0 = gen.
        always_comb begin
            dc[gi+1] = dc[gi] ? (gen_blk[gi] | prop_blk[gi]) : gen_blk[gi];
        end

        // Correction adder for this digit.
        always_comb begin
            sum_blk[4*gi +: 4] = fix_digit(raw_blk[5*gi +: 5], dc[gi], dc[gi+1]);
        end
    end
endmodule

// File: rtl/hbcd_adder.sv
// hbcd_adder: NDIG-digit decimal adder built from NDIG/MDIG lookahead groups,
// with a registered result. Assumes MDIG >= 1 and that MDIG divides NDIG.
module hbcd_adder #(
    parameter int NDIG = 8,
    parameter int MDIG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    input  logic              cin,
    output logic [4*NDIG-1:0] sum,
    output logic              cout
);
    localparam int NBLK = (MDIG >= 1) ? NDIG / MDIG : 1;
    localparam logic [4*NDIG-1:0] ALL_NINE = {NDIG{4'h9}};

    if (MDIG < 1 || (NDIG % MDIG) != 0) begin : g_bad_param
        $error("hbcd_adder: MDIG must be >= 1 and divide NDIG");
    end

    logic [5*NDIG-1:0] raw_vec;
    logic [NDIG-1:0]   gen_vec;
    logic [NDIG-1:0]   prop_vec;
    logic [NBLK:0]     bc;
    logic [NBLK-1:0]   chain_c;
    logic [4*NDIG-1:0] sum_d;
    logic [NDIG-1:0]   dig_ok;
    logic              in_ok;

    hbcd_digit_flags #(.NDIG(NDIG)) u_flags (
        .a        (a),
        .b        (b),
        .raw_vec  (raw_vec),
        .gen_vec  (gen_vec),
        .prop_vec (prop_vec)
    );

    assign bc[0] = cin;

    for (genvar gb = 0; gb < NBLK; gb++) begin : g_blk
        hbcd_block_lookahead #(.MDIG(MDIG)) u_la (
            .gen_blk  (gen_vec[gb*MDIG +: MDIG]),
            .prop_blk (prop_vec[gb*MDIG +: MDIG]),
            .blk_cin  (bc[gb]),
            .blk_cout (bc[gb+1])
        );

        hbcd_block_sum #(.MDIG(MDIG)) u_sum (
            .raw_blk    (raw_vec[5*gb*MDIG +: 5*MDIG]),
            .gen_blk    (gen_vec[gb*MDIG +: MDIG]),
            .prop_blk   (prop_vec[gb*MDIG +: MDIG]),
            .blk_cin    (bc[gb]),
            .sum_blk    (sum_d[4*gb*MDIG +: 4*MDIG]),
            .chain_cout (chain_c[gb])
        );

        AST_LA_MATCHES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_ok |-> chain_c[gb] == bc[gb+1])); // R8
    end

    // Validity of every operand digit, used only to qualify the checks.
    for (genvar gi = 0; gi < NDIG; gi++) begin : g_ok
        always_comb begin
            dig_ok[gi] = (a[4*gi +: 4] <= 4'd9) && (b[4*gi +: 4] <= 4'd9);
        end
    end
    assign in_ok = &dig_ok;

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum  <= '0;
            cout <= 1'b0;
        end else begin
            sum  <= sum_d;
            cout <= bc[NBLK];
        end
    end

    for (genvar gi = 0; gi < NDIG; gi++) begin : g_rng
        AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(in_ok) |-> sum[4*gi +: 4] <= 4'd9)); // R4
    end

    AST_PROP_PASSES_CIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && (&prop_vec)) |-> cout == $past(cin))); // R6

    AST_PROP_SUM_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && (&prop_vec)) |-> sum == ($past(cin) ? '0 : ALL_NINE))); // R6

    AST_ALL_GEN_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && in_ok && (&gen_vec)) |-> cout)); // R3
endmodule

// File: tb/hbcd_adder_tb.sv
// hbcd_adder_tb: directed scenarios on four instances with different group
// sizes, each compared against an integer-arithmetic decimal reference.
module hbcd_adder_tb;
    localparam int N_A = 8, M_A = 2;
    localparam int N_B = 6, M_B = 3;
    localparam int N_C = 4, M_C = 4;
    localparam int N_D = 5, M_D = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        op_c = 1'b0;

    logic [4*N_A-1:0] s_a;  logic co_a;
    logic [4*N_B-1:0] s_b;  logic co_b;
    logic [4*N_C-1:0] s_c;  logic co_c;
    logic [4*N_D-1:0] s_d;  logic co_d;

    int checks = 0;
    int failures = 0;
    logic [31:0] lf = 32'h1234_5679;

    always #2.5 clk = ~clk;

    hbcd_adder #(.NDIG(N_A), .MDIG(M_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .a(op_a[4*N_A-1:0]), .b(op_b[4*N_A-1:0]),
        .cin(op_c), .sum(s_a), .cout(co_a));
    hbcd_adder #(.NDIG(N_B), .MDIG(M_B)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .a(op_a[4*N_B-1:0]), .b(op_b[4*N_B-1:0]),
        .cin(op_c), .sum(s_b), .cout(co_b));
    hbcd_adder #(.NDIG(N_C), .MDIG(M_C)) u_dut_c (
        .clk(clk), .rst_n(rst_n), .a(op_a[4*N_C-1:0]), .b(op_b[4*N_C-1:0]),
        .cin(op_c), .sum(s_c), .cout(co_c));
    hbcd_adder #(.NDIG(N_D), .MDIG(M_D)) u_dut_d (
        .clk(clk), .rst_n(rst_n), .a(op_a[4*N_D-1:0]), .b(op_b[4*N_D-1:0]),
        .cin(op_c), .sum(s_d), .cout(co_d));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Decimal reference through integer arithmetic.
    task automatic ref_add(input logic [63:0] x, input logic [63:0] y, input logic c,
                           input int nd, output logic [63:0] s, output logic co);
        longint vx = 0, vy = 0, pw = 1, tot, r;
        for (int i = 0; i < nd; i++) begin
            vx += longint'(x[4*i +: 4]) * pw;
            vy += longint'(y[4*i +: 4]) * pw;
            pw *= 10;
        end
        tot = vx + vy + longint'(c);
        co = (tot >= pw);
        r = tot % pw;
        s = '0;
        for (int i = 0; i < nd; i++) begin
            s[4*i +: 4] = 4'(r % 10);
            r = r / 10;
        end
    endtask

    // Drive operands away from the edge, let one edge capture them.
    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c);
        @(negedge clk);
        op_a = x; op_b = y; op_c = c;
        @(posedge clk);
        #1;
    endtask

    // Compare all four instances with the reference.
    task automatic check_all(input string req);
        logic [63:0] es; logic ec;
        ref_add(op_a, op_b, op_c, N_A, es, ec);
        chk({req, " sum g2"}, 64'(s_a), es);  chk({req, " cout g2"}, 64'(co_a), 64'(ec));
        ref_add(op_a, op_b, op_c, N_B, es, ec);
        chk({req, " sum g3"}, 64'(s_b), es);  chk({req, " cout g3"}, 64'(co_b), 64'(ec));
        ref_add(op_a, op_b, op_c, N_C, es, ec);
        chk({req, " sum g4"}, 64'(s_c), es);  chk({req, " cout g4"}, 64'(co_c), 64'(ec));
        ref_add(op_a, op_b, op_c, N_D, es, ec);
        chk({req, " sum g1"}, 64'(s_d), es);  chk({req, " cout g1"}, 64'(co_d), 64'(ec));
    endtask

    function automatic logic [63:0] rnd_bcd();
        logic [63:0] v = '0;
        for (int i = 0; i < 16; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            v[4*i +: 4] = 4'(lf % 10);
        end
        return v;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        apply(64'h9999_9999, 64'h9999_9999, 1'b1);
        chk("R1 sum in reset", 64'(s_a), 64'd0);
        chk("R1 cout in reset", 64'(co_a), 64'd0);
        chk("R1 sum in reset g1", 64'(s_d), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        apply(64'h0000_0012, 64'h0000_0030, 1'b0);
        chk("R2 captured sum", 64'(s_a), 64'h42);
        @(negedge clk);
        op_a = 64'h7777_7777; op_b = 64'h7777_7777; op_c = 1'b1;
        #1;
        chk("R2 held between edges", 64'(s_a), 64'h42);
        chk("R2 cout held", 64'(co_a), 64'd0);
    endtask

    task automatic t_zero_and_max();
        apply('0, '0, 1'b0);
        check_all("R3 zero");
        apply(64'h9999_9999_9999_9999, 64'h9999_9999_9999_9999, 1'b1);
        check_all("R3 max");
        chk("R3 max sum g2", 64'(s_a), 64'h9999_9999);
        chk("R3 max cout g2", 64'(co_a), 64'd1);
    endtask

    task automatic t_packing();
        for (int k = 0; k < N_A; k++) begin
            logic [63:0] one = 64'(1) << (4*k);
            apply(one, one << 1, 1'b0);
            chk("R5 digit position", 64'(s_a), 64'(3) << (4*k));
        end
    endtask

    task automatic t_prop_all();
        logic [63:0] x = 64'h1234_5678_9012_3456;
        logic [63:0] y = '0;
        for (int i = 0; i < 16; i++) y[4*i +: 4] = 4'd9 - x[4*i +: 4];
        apply(x, y, 1'b0);
        chk("R6 all-prop cin0 sum", 64'(s_a), 64'h9999_9999);
        chk("R6 all-prop cin0 cout", 64'(co_a), 64'd0);
        check_all("R6 cin0");
        apply(x, y, 1'b1);
        chk("R6 all-prop cin1 sum", 64'(s_a), 64'd0);
        chk("R6 all-prop cin1 cout", 64'(co_a), 64'd1);
        check_all("R6 cin1");
    endtask

    // Low digit generates; upper digits propagate across group edges (R8 path).
    task automatic t_cross();
        apply(64'h4444_4444_4444_4445, 64'h5555_5555_5555_5557, 1'b0);
        chk("R7 carry to cout sum", 64'(s_a), 64'h0000_0002);
        chk("R7 carry to cout", 64'(co_a), 64'd1);
        check_all("R7 R8 long run");
        for (int k = 1; k < N_A; k++) begin
            logic [63:0] x = 64'h4444_4444_4444_4445;
            x[4*k +: 4] = 4'd3;
            apply(x, 64'h5555_5555_5555_5557, 1'b0);
            chk("R7 killed carry", 64'(co_a), 64'd0);
            check_all("R7 R8 kill");
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            logic [63:0] x = rnd_bcd();
            logic [63:0] y = rnd_bcd();
            apply(x, y, 1'(n & 1));
            check_all("R3 R9 random");
            for (int i = 0; i < N_A; i++)
                chk("R4 digit range", 64'(s_a[4*i +: 4] <= 4'd9), 64'd1);
        end
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        t_reset();
        t_latency();
        t_zero_and_max();
        t_packing();
        t_prop_all();
        t_cross();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule